// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O block on a simple word-addressed register bus. Software drives pins through an output-data register and an output-enable register, and reads their synchronized levels back. Each pin can also raise an interrupt. The trigger can be level or edge sensitive, and its polarity is selectable. Events latch into a status register. One port interrupt line combines every latched event that its enable mask lets through.

Every register can be reached at three aliases: a plain write, a bit-set write and a bit-clear write. This lets software change individual pins without a read-modify-write. Status bits can only be cleared, and only through the clear alias of the status register. Reads return the register value combinationally, in the same cycle the address is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, pin_oe_o and pin_o are 0 (all pins are inputs), and irq_o is 0.
- R2: Address bits [6:4] select the register: 0 output data, 1 input data, 2 output enable, 3 pin-to-interrupt enable, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Address bits [3:2] select the alias: 0 plain (offset +0x0), 1 set (+0x4), 2 clear (+0x8). Alias 3 and writes with address bits [1:0] not zero are ignored. A read at any alias returns the register.
- R3: A write to the set alias ORs the data into the register, and a write to the clear alias clears the bits that are 1 in the data; all other bits keep their value.
- R4: pin_o follows the output-data register and pin_oe_o follows the output-enable register (1 drives the pin, 0 makes it an input).
- R5: The input-data register returns pin_i after two synchronizer flops: a change appears at the second rising clock edge. Writes to it have no effect.
- R6: With level-select bit 0 (edge mode), polarity 1 detects a rising edge and polarity 0 a falling edge. The edge is found by comparing the synchronized level with its value one cycle earlier. The status bit is visible after the third rising clock edge following the pin change.
- R7: With level-select bit 1 (level mode), polarity 1 is active high and polarity 0 active low. The status bit is set again on every cycle the active level persists, so a clear issued while the level is still active has no lasting effect.
- R8: A status bit is set only while that pin's pin-to-interrupt enable bit is 1.
- R9: Status bits are cleared only by writing ones to the status clear alias (0x78). Plain and set writes to the status register are ignored. When a new event and a clear occur in the same cycle, the event wins.
- R10: irq_o is 1 exactly when the bitwise AND of status and interrupt enable is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte address: register in [6:4], alias in [3:2] |
| bus_wdata_i | input | 32 | Write data or bit mask |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| pin_i | input | 32 | Asynchronous pin levels |
| pin_o | output | 32 | Pin output data |
| pin_oe_o | output | 32 | Pin output enable |
| irq_o | output | 1 | Port interrupt |

## Verification
A wrong alias decode shows up at the next read: bits outside the mask change, or pin_o or pin_oe_o change in the cycle after the write. A wrong synchronizer depth or edge comparison moves the first cycle in which input data or status reads non-zero, so the bench samples the cycle before and the cycle after the expected edge. A stuck or wrongly gated status bit shows on irq_o, and on the status read, one cycle after the event or the clear. Level-mode re-setting is seen by a status read straight after a clear.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    REG_DOUT  = 3'd0,
    REG_DIN   = 3'd1,
    REG_DOE   = 3'd2,
    REG_PIRQ  = 3'd3,
    REG_IRQEN = 3'd4,
    REG_LVL   = 3'd5,
    REG_POL   = 3'd6,
    REG_STAT  = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_RSVD  = 2'd3
  } alias_e;

  localparam int unsigned ALIAS_LSB = 2;
  localparam int unsigned REG_LSB   = 4;
  localparam int unsigned REG_BITS  = 3;
  localparam int unsigned BUS_AW    = REG_LSB + REG_BITS;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= din_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall;
    assign rise     = din_i[i] & ~prev_q[i];
    assign fall     = ~din_i[i] & prev_q[i];
    assign evt_o[i] = lvl_i[i] ? (din_i[i] == pol_i[i])
                               : (pol_i[i] ? rise : fall);

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[i] && !lvl_i[i]) |-> (din_i[i] != $past(din_i[i]))); // R6
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [BUS_AW-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  typedef logic [NUM_PINS-1:0] vec_t;

  vec_t dout_q, doe_q, pirq_q, irqen_q, lvl_q, pol_q, stat_q;
  vec_t din_s, evt, stat_clr;
  reg_idx_e sel;
  alias_e   al;
  logic     wr;

  assign sel = reg_idx_e'(bus_addr_i[REG_LSB +: REG_BITS]);
  assign al  = alias_e'(bus_addr_i[ALIAS_LSB +: 2]);
  assign wr  = bus_en_i && bus_we_i && (al != AL_RSVD)
               && (bus_addr_i[ALIAS_LSB-1:0] == '0);

  function automatic vec_t upd(alias_e a, vec_t q, vec_t w);
    case (a)
      AL_SET:  return q | w;
      AL_CLR:  return q & ~w;
      default: return w;
    endcase
  endfunction

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(din_s)
  );

  gpio_evt_detect #(.WIDTH(NUM_PINS)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_s),
    .lvl_i(lvl_q), .pol_i(pol_q), .evt_o(evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      doe_q   <= '0;
      pirq_q  <= '0;
      irqen_q <= '0;
      lvl_q   <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      case (sel)
        REG_DOUT:  dout_q  <= upd(al, dout_q,  bus_wdata_i);
        REG_DOE:   doe_q   <= upd(al, doe_q,   bus_wdata_i);
        REG_PIRQ:  pirq_q  <= upd(al, pirq_q,  bus_wdata_i);
        REG_IRQEN: irqen_q <= upd(al, irqen_q, bus_wdata_i);
        REG_LVL:   lvl_q   <= upd(al, lvl_q,   bus_wdata_i);
        REG_POL:   pol_q   <= upd(al, pol_q,   bus_wdata_i);
        default:   ;
      endcase
    end
  end

  // status: clear alias only; new events override a same-cycle clear
  assign stat_clr = (wr && sel == REG_STAT && al == AL_CLR) ? bus_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr) | (evt & pirq_q);
  end

  always_comb begin
    case (sel)
      REG_DOUT:  bus_rdata_o = dout_q;
      REG_DIN:   bus_rdata_o = din_s;
      REG_DOE:   bus_rdata_o = doe_q;
      REG_PIRQ:  bus_rdata_o = pirq_q;
      REG_IRQEN: bus_rdata_o = irqen_q;
      REG_LVL:   bus_rdata_o = lvl_q;
      REG_POL:   bus_rdata_o = pol_q;
      REG_STAT:  bus_rdata_o = stat_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = doe_q;
  assign irq_o    = |(stat_q & irqen_q);

  AST_STAT_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(pirq_q)) == '0)); // R8

  AST_STAT_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(stat_q) & ~stat_q) != '0) |->
     $past(wr && sel == REG_STAT && al == AL_CLR))); // R9

  AST_SET_KEEPS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == REG_DOUT && al == AL_SET) |=>
    ((pin_o & $past(pin_o)) == $past(pin_o))); // R3

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr && sel == REG_DOE) |-> $stable(pin_oe_o)); // R4
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int unsigned N = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bus_en_i = 1'b0;
  logic         bus_we_i = 1'b0;
  logic [6:0]   bus_addr_i = '0;
  logic [N-1:0] bus_wdata_i = '0;
  logic [N-1:0] bus_rdata_o;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o, pin_oe_o;
  logic         irq_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [6:0] A_DOUT = 7'h00, A_DIN = 7'h10, A_DOE = 7'h20,
    A_PIRQ = 7'h30, A_IRQEN = 7'h40, A_LVL = 7'h50, A_POL = 7'h60, A_STAT = 7'h70;
  localparam logic [6:0] SET = 7'h4, CLR = 7'h8, RSV = 7'hC;

  gpio_irq_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [N-1:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic rchk(input string req, input logic [6:0] a, input logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk_i);
    pin_i[idx] = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic t_reset();
    for (int r = 0; r < 8; r++) rchk("R1 reg", 7'(r * 16), '0);
    chk("R1 pin_o", pin_o, '0);
    chk("R1 pin_oe_o", pin_oe_o, '0);
    chk("R1 irq_o", N'(irq_o), '0);
  endtask

  task automatic t_alias();
    wr(A_DOUT, 32'hA5A5_0F0F);
    rchk("R2 plain write", A_DOUT, 32'hA5A5_0F0F);
    chk("R4 pin_o", pin_o, 32'hA5A5_0F0F);
    wr(A_DOUT + SET, 32'h0000_00F0);
    rchk("R3 set alias", A_DOUT, 32'hA5A5_0FFF);
    wr(A_DOUT + CLR, 32'hA500_0000);
    rchk("R3 clr alias", A_DOUT, 32'h00A5_0FFF);
    rchk("R2 read via set alias", A_DOUT + SET, 32'h00A5_0FFF);
    wr(A_DOE, 32'hFFFF_0000);
    chk("R4 pin_oe_o", pin_oe_o, 32'hFFFF_0000);
    wr(A_DOE + RSV, 32'hFFFF_FFFF);
    rchk("R2 reserved alias ignored", A_DOE, 32'hFFFF_0000);
    wr(A_DOE + 7'h1, 32'h0000_FFFF);
    rchk("R2 unaligned write ignored", A_DOE, 32'hFFFF_0000);
    wr(A_DOE + CLR, 32'hFFFF_FFFF);
    chk("R4 pin_oe_o cleared", pin_oe_o, '0);
  endtask

  task automatic t_din();
    @(negedge clk_i);
    pin_i = 32'h1234_5678;
    edges(1);
    rchk("R5 din not yet after 1 edge", A_DIN, '0);
    edges(1);
    rchk("R5 din after 2 edges", A_DIN, 32'h1234_5678);
    wr(A_DIN, 32'hFFFF_FFFF);
    rchk("R5 din write ignored", A_DIN, 32'h1234_5678);
    @(negedge clk_i);
    pin_i = '0;
    edges(3);
    rchk("R8 no status when unarmed", A_STAT, '0);
  endtask

  task automatic t_edge();
    wr(A_POL + SET, 32'h1);
    wr(A_PIRQ + SET, 32'h3);
    wr(A_IRQEN + SET, 32'h3);
    set_pin(0, 1'b1);
    edges(2);
    rchk("R6 rise not yet after 2 edges", A_STAT, '0);
    edges(1);
    rchk("R6 rise latched after 3 edges", A_STAT, 32'h1);
    chk("R10 irq_o set", N'(irq_o), 1);
    wr(A_STAT + CLR, 32'h1);
    rchk("R9 clear alias", A_STAT, '0);
    chk("R10 irq_o cleared", N'(irq_o), 0);
    set_pin(0, 1'b0);
    edges(3);
    rchk("R6 fall ignored on rising pin", A_STAT, '0);
    set_pin(1, 1'b1);
    edges(3);
    rchk("R6 rise ignored on falling pin", A_STAT, '0);
    set_pin(1, 1'b0);
    edges(3);
    rchk("R6 fall latched", A_STAT, 32'h2);
    wr(A_STAT + CLR, 32'h2);
  endtask

  task automatic t_arm();
    wr(A_POL + SET, 32'hC);
    set_pin(2, 1'b1);
    edges(3);
    rchk("R8 unarmed pin no status", A_STAT, '0);
    wr(A_PIRQ + SET, 32'h8);
    set_pin(3, 1'b1);
    edges(3);
    rchk("R8 armed pin status", A_STAT, 32'h8);
    chk("R10 masked irq_o low", N'(irq_o), 0);
    wr(A_IRQEN + SET, 32'h8);
    chk("R10 unmasked irq_o high", N'(irq_o), 1);
    wr(A_STAT, 32'h0);
    rchk("R9 plain write ignored", A_STAT, 32'h8);
    wr(A_STAT + SET, 32'hFFFF_FFFF);
    rchk("R9 set write ignored", A_STAT, 32'h8);
    wr(A_STAT + CLR, 32'h8);
    rchk("R9 cleared", A_STAT, '0);
  endtask

  task automatic t_level();
    wr(A_LVL + SET, 32'h10);
    wr(A_POL + SET, 32'h10);
    wr(A_PIRQ + SET, 32'h10);
    set_pin(4, 1'b1);
    edges(3);
    rchk("R7 high level latched", A_STAT, 32'h10);
    wr(A_STAT + CLR, 32'h10);
    rchk("R7 clear while active re-sets", A_STAT, 32'h10);
    set_pin(4, 1'b0);
    edges(3);
    rchk("R7 status stays latched", A_STAT, 32'h10);
    wr(A_STAT + CLR, 32'h10);
    rchk("R7 clear after level gone", A_STAT, '0);
    wr(A_LVL + SET, 32'h20);
    rchk("R8 low level unarmed", A_STAT, '0);
    wr(A_PIRQ + SET, 32'h20);
    rchk("R7 low level latched", A_STAT, 32'h20);
    wr(A_PIRQ + CLR, 32'h20);
    wr(A_STAT + CLR, 32'h20);
    rchk("R8 disarmed level stays clear", A_STAT, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_alias();
    t_din();
    t_edge();
    t_arm();
    t_level();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule